// File: doc/BRIEF.md
# SPI Master Controller with Collision and Mode-Fault Detection

This block is the master side of a four-wire synchronous serial link. Software programs a small set of byte-wide registers over a simple strobe bus. A write to the data register starts an 8-bit exchange. During the exchange the block shifts the written byte out on MOSI, most significant bit first. At the same time it gathers the byte arriving on MISO, and it generates SCK from a divided system clock. The clock idle level and the sampling edge are programmable, which gives the four usual transfer formats. The SCK rate is one of eight power-of-two divisions of the system clock.

A select register picks which of eight active-low slave-select lines go low for the length of a transfer. Those lines fall half an SCK period before the first clock edge and rise half a period after the last one. Two error conditions are tracked. The first is a data write that arrives while a transfer is still running. The second is another master claiming the bus through the mode-fault input. A fault drops the master-enable bit and tri-states SCK, MOSI and the selects until software enables the block again. A single interrupt line combines the transfer-done flag and the two error flags through a per-flag mask.

Register map (3-bit address): 0 = control, 1 = status, 2 = data, 3 = interrupt mask, 4 = slave select. Other addresses read as zero.

Top module: `spi_fault_master`

## Requirements
- R1: After reset, SCK is 0, all slave selects are high, all output enables and the interrupt are low, and the control and status registers read 0.
- R2: Control bit 0 enables the master, bit 1 sets the SCK idle level (CPOL), and bit 2 (CPHA) selects sampling on the leading edge (0) or the trailing edge (1). A transfer makes 16 SCK edges, sends the written byte on MOSI MSB first, returns the MISO byte on a data-register read, and leaves SCK at its idle level.
- R3: The rate field in control bits 5:3 sets the half SCK period to 2 << rate system clocks, so a full period runs from clk/4 (rate 0) to clk/512 (rate 7).
- R4: During a transfer, slave select line i is low exactly when bit i of the select register is 1. The lines go low in the cycle after the data write and rise one half SCK period after the last edge.
- R5: Status bit 0 (done) sets when a transfer ends. A data-register access clears it only if a status read that saw done = 1 came first; a data access alone leaves it set.
- R6: A data write while a transfer runs sets status bit 1 (write collision). The running transfer still sends the original byte and ends on time.
- R7: While control bit 0 is set, a high mode-fault input clears control bit 0 on the next edge, drops the SCK, MOSI and select enables, aborts any transfer, and sets status bit 2.
- R8: Writing 1 to status bit 1 or bit 2 clears that flag. Writing 0 to it leaves it unchanged.
- R9: The interrupt is high when any status flag (bits 0 to 2) is set together with the matching bit of the mask register (bits 0 to 2).
- R10: A data write while control bit 0 is clear starts no transfer: the busy bit (status bit 3) stays 0 and the selects stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for the addressed register |
| miso | input | 1 | Serial data from the slave |
| mode_fault | input | 1 | High when another master drives the bus (synchronous) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| sel_n | output | DW | Active-low slave selects |
| sck_oe | output | 1 | Output enable for SCK |
| mosi_oe | output | 1 | Output enable for MOSI |
| sel_oe | output | 1 | Output enable for the slave selects |
| irq | output | 1 | Masked interrupt request |

## Verification
The properties assume that software leaves the control and select registers alone while a transfer runs, and that mode_fault is already synchronous to clk. The quiet-SCK and stable-select checks rely on both. The stimulus follows these rules. It changes configuration only between transfers, and it raises mode_fault only for one whole clock cycle between falling edges. The random transfers vary format, rate, select pattern, data and the timing of a colliding write.

// File: rtl/spi_fault_master.sv
module spi_fault_master #(
  parameter int DW    = 8,
  parameter int RATEW = 3,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          miso,
  input  logic          mode_fault,
  output logic          sck,
  output logic          mosi,
  output logic [DW-1:0] sel_n,
  output logic          sck_oe,
  output logic          mosi_oe,
  output logic          sel_oe,
  output logic          irq
);
  localparam int EDGES = 2 * DW;
  localparam int ECW   = $clog2(EDGES + 1);
  localparam int CW    = (1 << RATEW) + 1;
  localparam int NFLAG = 3;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_DATA = AW'(2);
  localparam logic [AW-1:0] A_MASK = AW'(3);
  localparam logic [AW-1:0] A_SEL  = AW'(4);

  logic             en, cpol, cpha;
  logic [RATEW-1:0] rate;
  logic [NFLAG-1:0] mask;
  logic [DW-1:0]    selreg, rxd, sreg;
  logic             busy, done, wcol, mflt, armed, rbit, ph;
  logic [ECW-1:0]   ecnt;
  logic [CW-1:0]    cnt;

  wire [CW-1:0] half_m1  = (CW'(2) << rate) - CW'(1);
  wire          tick     = busy && (cnt == '0);
  wire          last     = (ecnt == ECW'(EDGES));
  wire          edge_now = tick && !last;
  wire          lead     = ~ecnt[0];
  wire          samp     = edge_now && (lead ^ cpha);
  wire          shft     = edge_now && !(lead ^ cpha) && (ecnt != '0);
  wire          fin      = tick && last;

  wire wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  wire wr_stat  = bus_wr && (bus_addr == A_STAT);
  wire wr_data  = bus_wr && (bus_addr == A_DATA);
  wire wr_mask  = bus_wr && (bus_addr == A_MASK);
  wire wr_sel   = bus_wr && (bus_addr == A_SEL);
  wire rd_stat  = bus_rd && (bus_addr == A_STAT);
  wire data_acc = (bus_wr || bus_rd) && (bus_addr == A_DATA);
  wire fault    = mode_fault && en;
  wire start    = wr_data && en && !busy && !fault;

  wire [DW-1:0] rx_final = cpha ? {sreg[DW-2:0], rbit} : sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      cpol   <= 1'b0;
      cpha   <= 1'b0;
      rate   <= '0;
      mask   <= '0;
      selreg <= '0;
    end else begin
      if (wr_ctrl) {rate, cpha, cpol, en} <= bus_wdata[RATEW+2:0];
      if (fault)   en <= 1'b0;
      if (wr_mask) mask <= bus_wdata[NFLAG-1:0];
      if (wr_sel)  selreg <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      ecnt <= '0;
      sreg <= '0;
      rxd  <= '0;
      rbit <= 1'b0;
      ph   <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= half_m1;
      ecnt <= '0;
      sreg <= bus_wdata;
      ph   <= 1'b0;
    end else if (busy) begin
      if (fault || !en) begin
        busy <= 1'b0;
        ph   <= 1'b0;
      end else if (tick) begin
        cnt <= half_m1;
        if (last) begin
          busy <= 1'b0;
          rxd  <= rx_final;
        end else begin
          ecnt <= ecnt + 1'b1;
          ph   <= ~ph;
        end
        if (samp) rbit <= miso;
        if (shft) sreg <= {sreg[DW-2:0], rbit};
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      armed <= 1'b0;
      wcol  <= 1'b0;
      mflt  <= 1'b0;
    end else begin
      if (fin) begin
        done  <= 1'b1;
        armed <= 1'b0;
      end else if (data_acc && armed) begin
        done  <= 1'b0;
        armed <= 1'b0;
      end else if (rd_stat && done) begin
        armed <= 1'b1;
      end

      if (wr_data && busy)              wcol <= 1'b1;
      else if (wr_stat && bus_wdata[1]) wcol <= 1'b0;

      if (fault)                        mflt <= 1'b1;
      else if (wr_stat && bus_wdata[2]) mflt <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[RATEW+2:0] = {rate, cpha, cpol, en};
      A_STAT:  bus_rdata[3:0]       = {busy, mflt, wcol, done};
      A_DATA:  bus_rdata            = rxd;
      A_MASK:  bus_rdata[NFLAG-1:0] = mask;
      A_SEL:   bus_rdata            = selreg;
      default: bus_rdata            = '0;
    endcase
  end

  assign sck     = cpol ^ ph;
  assign mosi    = sreg[DW-1];
  assign sel_n   = busy ? ~selreg : '1;
  assign sck_oe  = en;
  assign mosi_oe = en;
  assign sel_oe  = en;
  assign irq     = |({mflt, wcol, done} & mask);
endmodule

// File: rtl/spi_fault_master_sva.sv
module spi_fault_master_sva #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic          mode_fault,
  input logic          sck,
  input logic          sck_oe,
  input logic          mosi_oe,
  input logic          sel_oe,
  input logic          irq,
  input logic          en,
  input logic          busy,
  input logic          done,
  input logic          wcol,
  input logic [2:0]    mask,
  input logic [DW-1:0] sel_n
);
  a_r7_fault_release: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_fault && en) |=> (!sck_oe && !mosi_oe && !sel_oe && !busy));

  a_r4_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(sel_n));

  a_r2_sck_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(bus_wr && bus_addr == AW'(0))) |=> $stable(sck));

  a_r5_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) && !busy));

  a_r6_wcol_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(2) && busy) |=> wcol);

  a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 3'b000) |-> !irq);

  a_r10_no_start_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && bus_wr && bus_addr == AW'(2)) |=> !busy);
endmodule

bind spi_fault_master spi_fault_master_sva #(.DW(DW), .AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .mode_fault(mode_fault), .sck(sck), .sck_oe(sck_oe), .mosi_oe(mosi_oe),
  .sel_oe(sel_oe), .irq(irq), .en(en), .busy(busy), .done(done),
  .wcol(wcol), .mask(mask), .sel_n(sel_n)
);

// File: tb/tb_spi_fault_master.sv
module tb_spi_fault_master;
  localparam int CLK_P = 10;
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_DATA = 3'd2, A_MASK = 3'd3, A_SEL = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic miso = 1'b0, mode_fault = 1'b0;
  logic sck, mosi, sck_oe, mosi_oe, sel_oe, irq;
  logic [7:0] sel_n;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_fault_master dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .miso(miso), .mode_fault(mode_fault),
    .sck(sck), .mosi(mosi), .sel_n(sel_n), .sck_oe(sck_oe), .mosi_oe(mosi_oe),
    .sel_oe(sel_oe), .irq(irq)
  );

  function automatic int half_of(input logic [2:0] r);
    return 2 << r;
  endfunction

  function automatic logic [7:0] ctrl_word(input logic [2:0] r, input logic ph, input logic pol, input logic e);
    return {2'b00, r, ph, pol, e};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic xfer(input logic [1:0] mode, input logic [2:0] rate, input logic [7:0] sel,
                      input logic [7:0] mtx, input logic [7:0] stx, input int coll_at);
    int h, ecount;
    bit t_ok, s_ok;
    logic prev, cpol, cpha;
    logic [7:0] sh, s_rx, v;
    cpol = mode[0]; cpha = mode[1];
    h = half_of(rate);
    wr(A_CTRL, ctrl_word(rate, cpha, cpol, 1'b1));
    wr(A_SEL, sel);
    sh = stx; s_rx = '0;
    if (!cpha) begin miso = sh[7]; sh = sh << 1; end
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_DATA; bus_wdata = mtx;
    @(negedge clk);
    bus_wr = 1'b0;
    chk(sel_n == ~sel, "R4 select asserted", sel_n, ~sel);
    chk(sck == cpol, "R2 sck idle before edge", sck, cpol);
    prev = sck; ecount = 0; t_ok = 1; s_ok = 1;
    for (int n = 0; n <= 17*h; n++) begin
      if (sck != prev) begin
        if (n != (ecount + 1) * h) t_ok = 0;
        if ((ecount % 2) == 0) begin
          if (!cpha) s_rx = {s_rx[6:0], mosi};
          else begin miso = sh[7]; sh = sh << 1; end
        end else begin
          if (cpha) s_rx = {s_rx[6:0], mosi};
          else begin miso = sh[7]; sh = sh << 1; end
        end
        ecount++;
        prev = sck;
      end
      if (n < 17*h && sel_n != ~sel) s_ok = 0;
      if (n == 17*h && sel_n != 8'hFF) s_ok = 0;
      if (n == coll_at) begin bus_wr = 1'b1; bus_addr = A_DATA; bus_wdata = ~mtx; end
      if (n == coll_at + 1) bus_wr = 1'b0;
      if (n < 17*h) @(negedge clk);
    end
    chk(ecount == 16, "R2 edge count", ecount, 16);
    chk(t_ok, "R3 edge spacing", t_ok, 1);
    chk(s_ok, "R4 select window", s_ok, 1);
    chk(s_rx == mtx, "R2 mosi byte (R6 when collided)", s_rx, mtx);
    chk(sck == cpol, "R2 sck idle after", sck, cpol);
    rd(A_STAT, v);
    chk(v[0] == 1'b1 && v[3] == 1'b0, "R5 done set", v, 8'h01);
    chk(v[1] == (coll_at >= 0), "R6 write collision flag", v[1], coll_at >= 0);
    rd(A_DATA, v);
    chk(v == stx, "R2 miso byte", v, stx);
    rd(A_STAT, v);
    chk(v[0] == 1'b0, "R5 done cleared", v[0], 0);
    if (coll_at >= 0) wr(A_STAT, 8'h02);
  endtask

  initial begin
    #(CLK_P * 190000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sel_n == 8'hFF && sck == 1'b0 && !irq, "R1 outputs after reset", {sel_n, sck, irq}, 10'h3FC);
    chk(!sck_oe && !mosi_oe && !sel_oe, "R1 enables off", {sck_oe, mosi_oe, sel_oe}, 0);
    rd(A_CTRL, v); chk(v == 8'h00, "R1 control reset", v, 0);
    rd(A_STAT, v); chk(v == 8'h00, "R1 status reset", v, 0);

    wr(A_SEL, 8'h0F);
    wr(A_DATA, 8'h3C);
    chk(sel_n == 8'hFF, "R10 selects idle while disabled", sel_n, 8'hFF);
    rd(A_STAT, v); chk(v[3] == 1'b0, "R10 no busy while disabled", v, 0);

    for (int m = 0; m < 4; m++) begin
      xfer(2'(m), 3'd0, 8'h81, 8'hA5, 8'h3C, -1);
      xfer(2'(m), 3'd7, 8'h40, 8'h5E, 8'hC3, -1);
    end
    xfer(2'd1, 3'd0, 8'h00, 8'hFF, 8'h00, -1);

    for (int i = 0; i < 24; i++) begin
      logic [2:0] r;
      int c;
      r = 3'($urandom % 6);
      c = (i % 3 == 0) ? 1 + int'($urandom % (16 * half_of(r) - 1)) : -1;
      xfer(2'($urandom), r, 8'($urandom), 8'($urandom), 8'($urandom), c);
    end

    wr(A_CTRL, ctrl_word(3'd0, 1'b0, 1'b0, 1'b1));
    wr(A_DATA, 8'h11);
    repeat (40) @(negedge clk);
    rd(A_DATA, v);
    rd(A_STAT, v); chk(v[0] == 1'b1, "R5 data read alone keeps done", v[0], 1);
    rd(A_DATA, v);
    rd(A_STAT, v); chk(v[0] == 1'b0, "R5 status then data clears done", v[0], 0);

    wr(A_DATA, 8'h22);
    wr(A_DATA, 8'h33);
    rd(A_STAT, v); chk(v[1] == 1'b1, "R6 collision flagged", v[1], 1);
    wr(A_MASK, 3'b000);
    chk(!irq, "R9 masked flag gives no irq", irq, 0);
    wr(A_MASK, 3'b010);
    chk(irq, "R9 unmasked collision raises irq", irq, 1);
    wr(A_STAT, 8'h00);
    rd(A_STAT, v); chk(v[1] == 1'b1, "R8 write 0 keeps flag", v[1], 1);
    wr(A_STAT, 8'h02);
    rd(A_STAT, v); chk(v[1] == 1'b0, "R8 write 1 clears flag", v[1], 0);
    chk(!irq, "R9 irq drops with flag", irq, 0);
    repeat (40) @(negedge clk);
    wr(A_MASK, 3'b001);
    chk(irq, "R9 done raises irq when unmasked", irq, 1);
    rd(A_STAT, v); rd(A_DATA, v);
    chk(!irq, "R9 irq drops after done cleared", irq, 0);

    wr(A_CTRL, ctrl_word(3'd2, 1'b0, 1'b1, 1'b1));
    chk(sck_oe && mosi_oe && sel_oe, "R7 enables on when mastering", {sck_oe, mosi_oe, sel_oe}, 7);
    wr(A_DATA, 8'h99);
    repeat (20) @(negedge clk);
    mode_fault = 1'b1;
    @(negedge clk);
    mode_fault = 1'b0;
    chk(!sck_oe && !mosi_oe && !sel_oe, "R7 enables dropped", {sck_oe, mosi_oe, sel_oe}, 0);
    chk(sel_n == 8'hFF && sck == 1'b1, "R7 transfer aborted", {sel_n, sck}, 9'h1FF);
    rd(A_CTRL, v); chk(v[0] == 1'b0, "R7 master enable cleared", v[0], 0);
    rd(A_STAT, v); chk(v[2] == 1'b1 && v[3] == 1'b0, "R7 fault flag set", v, 8'h04);
    wr(A_DATA, 8'h77);
    rd(A_STAT, v); chk(v[3] == 1'b0 && sel_n == 8'hFF, "R7 no transfer until enabled", v, 0);
    wr(A_MASK, 3'b100);
    chk(irq, "R9 fault irq", irq, 1);
    wr(A_STAT, 8'h04);
    chk(!irq, "R8 fault flag cleared", irq, 0);
    wr(A_CTRL, ctrl_word(3'd2, 1'b0, 1'b1, 1'b1));
    chk(sck_oe && mosi_oe && sel_oe, "R7 enables back after re-enable", {sck_oe, mosi_oe, sel_oe}, 7);

    summary();
  end
endmodule